// File: doc/BRIEF.md
# Dual Memory Bus Timing Controller

This block sits on the host side of a 32-bit memory module that holds a static RAM bank and a flash bank. Both banks share one 17-bit address bus and one 32-bit data bus. The host issues one single-word request at a time. Each request carries a read/write flag, a bank select and a 4-bit byte mask. The controller then drives the module pins for that access. These pins are a chip select for each bank, one output enable shared by both banks, and four active-low write strobes per bank, one for each byte lane.

Every access runs through four phases: idle, setup, strobe and recovery. The strobe and recovery lengths are whole clock cycles. They are computed at elaboration from nanosecond figures and the `CLK_PERIOD_NS` parameter, always rounded up. A `FLASH_GRADE` parameter selects one of three flash speed sets: 0 is 70 ns, 1 is 90 ns and 2 is 120 ns. The data drivers are off for the whole of a read. The setup cycle therefore always separates driver release from the falling output enable. Read data is latched on the last strobe edge, and a one-cycle `done` pulse marks the end of each access.

Top module: `dual_bank_mem_ctrl`

## Requirements
- R1: While reset is held, both chip selects, the output enable and all eight write strobes are high, the data drivers are off, `req_ready` is 1 and `done` is 0.
- R2: The RAM chip select and the flash chip select are never low in the same cycle.
- R3: Output enable goes low only for reads, only while the addressed bank's chip select is low and all write strobes are high. The data drivers are off in the cycle where it falls and in the cycle before that.
- R4: A RAM read holds output enable low for ceil(25 ns / period) cycles and then releases the bus for ceil(12 ns / period) cycles before `done`.
- R5: A flash read holds output enable low for ceil(t_rc / period) cycles, where t_rc is 70, 90 or 120 ns by grade, and then allows ceil(t_float / period) recovery cycles, where t_float is 20, 25 or 30 ns.
- R6: A RAM write pulses `ram_we_n[i]` low for ceil(20 ns / period) cycles for every lane i whose mask bit is 1. Lane i carries data bits 8i+7 to 8i. No flash strobe moves during a RAM write, and the whole access spans at least ceil(25 ns / period) cycles.
- R7: A flash write pulses the masked `flash_we_n` lanes low for ceil(45 ns / period) cycles (50 ns at grade 2). Between two flash strobe pulses the strobes stay high for at least ceil(20 ns / period) cycles.
- R8: While any write strobe is low, and in the cycle after it rises, the address and write data stay unchanged and the data drivers stay on.
- R9: Read data from the bus is presented on `rdata` when `done` pulses and is held unchanged through later writes until the next read.
- R10: `req_ready` is high only in idle, and a request presented while busy is ignored. Each accepted request yields exactly one single-cycle `done` pulse, one cycle after recovery ends. The latency from the accept edge to `done` is strobe + recovery + 2 cycles.
- R11: A write with mask 0000 asserts no write strobe but still completes its timing and pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_flash | input | 1 | 1 = flash bank, 0 = RAM bank |
| req_mask | input | 4 | Byte-lane mask for writes, bit i = lane i |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read word |
| mem_addr | output | 17 | Shared address bus |
| mem_dq_out | output | 32 | Data toward the module |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 32 | Data from the module |
| ram_cs_n | output | 1 | RAM chip select, active low |
| flash_cs_n | output | 1 | Flash chip select, active low |
| oe_n | output | 1 | Shared output enable, active low |
| ram_we_n | output | 4 | RAM byte-lane write strobes, active low |
| flash_we_n | output | 4 | Flash byte-lane write strobes, active low |

## Verification
The assertions assume three things about the block's inputs:
- `CLK_PERIOD_NS` matches the real clock.
- The memory places valid data on `mem_dq_in` before the last strobe edge of a read.
- The host only samples `done` in the cycle it pulses.

The bench's memory model meets these assumptions. It drives read data half a cycle after output enable falls and drives a junk pattern otherwise, so a capture at the wrong edge shows up as a wrong word. It commits bytes only on the rising edge of a lane strobe. Requests are issued one at a time, except for one deliberate overlap that tests the busy-ignore rule.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_t;

  localparam int unsigned RAM_ACCESS_NS = 25;
  localparam int unsigned RAM_FLOAT_NS  = 12;
  localparam int unsigned RAM_PULSE_NS  = 20;
  localparam int unsigned RAM_CYCLE_NS  = 25;
  localparam int unsigned FLASH_HIGH_NS = 20;

  // ceil(ns / per), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // what remains of a total once some cycles are used, clamped at zero
  function automatic int unsigned remain(input int unsigned total, input int unsigned used);
    return (total > used) ? total - used : 0;
  endfunction

  function automatic int unsigned flash_cycle_ns(input int unsigned grade);
    case (grade)
      0:       return 70;
      1:       return 90;
      default: return 120;
    endcase
  endfunction

  function automatic int unsigned flash_pulse_ns(input int unsigned grade);
    return (grade >= 2) ? 50 : 45;
  endfunction

  function automatic int unsigned flash_float_ns(input int unsigned grade);
    case (grade)
      0:       return 20;
      1:       return 25;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/memctl_timing.sv
module memctl_timing
  import memctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned FLASH_GRADE   = 0,
  parameter int unsigned CNT_W         = 8
) (
  input  logic             sel_flash,
  input  logic             sel_write,
  output logic [CNT_W-1:0] strobe_len,
  output logic [CNT_W-1:0] recov_len
);

  localparam int unsigned RAM_RD_STB = ns_to_cyc(RAM_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned RAM_RD_REC = ns_to_cyc(RAM_FLOAT_NS, CLK_PERIOD_NS);
  localparam int unsigned RAM_WR_STB = ns_to_cyc(RAM_PULSE_NS, CLK_PERIOD_NS);
  // setup (1) + strobe + recovery must cover the full write cycle
  localparam int unsigned RAM_WR_REC =
    larger(1, remain(ns_to_cyc(RAM_CYCLE_NS, CLK_PERIOD_NS), 1 + RAM_WR_STB));
  localparam int unsigned FL_RD_STB  = ns_to_cyc(flash_cycle_ns(FLASH_GRADE), CLK_PERIOD_NS);
  localparam int unsigned FL_RD_REC  = ns_to_cyc(flash_float_ns(FLASH_GRADE), CLK_PERIOD_NS);
  localparam int unsigned FL_WR_STB  = ns_to_cyc(flash_pulse_ns(FLASH_GRADE), CLK_PERIOD_NS);
  localparam int unsigned FL_WR_REC  =
    larger(ns_to_cyc(FLASH_HIGH_NS, CLK_PERIOD_NS),
           remain(FL_RD_STB, 1 + FL_WR_STB));

  always_comb begin
    case ({sel_flash, sel_write})
      2'b00: begin strobe_len = CNT_W'(RAM_RD_STB); recov_len = CNT_W'(RAM_RD_REC); end
      2'b01: begin strobe_len = CNT_W'(RAM_WR_STB); recov_len = CNT_W'(RAM_WR_REC); end
      2'b10: begin strobe_len = CNT_W'(FL_RD_STB);  recov_len = CNT_W'(FL_RD_REC);  end
      default: begin strobe_len = CNT_W'(FL_WR_STB); recov_len = CNT_W'(FL_WR_REC); end
    endcase
  end

endmodule

// File: rtl/memctl_seq.sv
module memctl_seq
  import memctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] recov_len,
  output phase_t           phase,
  output logic             strobe_last,
  output logic             recov_last
);

  logic [CNT_W-1:0] cnt;

  assign strobe_last = (phase == PH_STROBE) && (cnt == '0);
  assign recov_last  = (phase == PH_RECOV)  && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= '0;
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= strobe_len - 1'b1;
        end
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_RECOV;
          cnt   <= recov_len - 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R4: a strobe phase is never entered with a zero length
  assert_strobe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |-> (strobe_len != '0));
  // R10: phase advances out of setup unconditionally
  assert_setup_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_STROBE));

endmodule

// File: rtl/memctl_lanes.sv
module memctl_lanes
  import memctl_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  phase_t           phase,
  input  logic             sel_flash,
  input  logic             sel_write,
  input  logic [LANES-1:0] mask,
  output logic             ram_cs_n,
  output logic             flash_cs_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic [LANES-1:0] ram_we_n,
  output logic [LANES-1:0] flash_we_n
);

  logic selected;
  logic strobing;

  assign selected   = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign strobing   = (phase == PH_STROBE);
  assign ram_cs_n   = !(selected && !sel_flash);
  assign flash_cs_n = !(selected &&  sel_flash);
  assign oe_n       = !(strobing && !sel_write);
  assign dq_oe      = sel_write && (phase != PH_IDLE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ram_we_n[i]   = !(strobing && sel_write && !sel_flash && mask[i]);
    assign flash_we_n[i] = !(strobing && sel_write &&  sel_flash && mask[i]);
  end

endmodule

// File: rtl/dual_bank_mem_ctrl.sv
module dual_bank_mem_ctrl
  import memctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned FLASH_GRADE   = 0,
  parameter int unsigned CNT_W         = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_flash,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                ram_cs_n,
  output logic                flash_cs_n,
  output logic                oe_n,
  output logic [DATA_W/8-1:0] ram_we_n,
  output logic [DATA_W/8-1:0] flash_we_n
);

  localparam int unsigned LANES = DATA_W / 8;

  phase_t             phase;
  logic               accept;
  logic               strobe_last;
  logic               recov_last;
  logic               kind_flash, kind_write;
  logic [LANES-1:0]   mask_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               done_q;
  logic [CNT_W-1:0]   strobe_len, recov_len;
  logic               any_we_low;

  assign req_ready  = (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rdata      = rdata_q;
  assign done       = done_q;
  assign any_we_low = !(&ram_we_n) || !(&flash_we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_flash <= 1'b0;
      kind_write <= 1'b0;
      mask_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else if (accept) begin
      kind_flash <= req_flash;
      kind_write <= req_write;
      mask_q     <= req_mask;
      addr_q     <= req_addr;
      wdata_q    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= recov_last;
      if (strobe_last && !kind_write) rdata_q <= mem_dq_in;
    end
  end

  memctl_timing #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .FLASH_GRADE(FLASH_GRADE), .CNT_W(CNT_W)
  ) u_timing (
    .sel_flash(kind_flash), .sel_write(kind_write),
    .strobe_len(strobe_len), .recov_len(recov_len)
  );

  memctl_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .strobe_len(strobe_len), .recov_len(recov_len),
    .phase(phase), .strobe_last(strobe_last), .recov_last(recov_last)
  );

  memctl_lanes #(.LANES(LANES)) u_lanes (
    .phase(phase), .sel_flash(kind_flash), .sel_write(kind_write), .mask(mask_q),
    .ram_cs_n(ram_cs_n), .flash_cs_n(flash_cs_n), .oe_n(oe_n), .dq_oe(mem_dq_oe),
    .ram_we_n(ram_we_n), .flash_we_n(flash_we_n)
  );

  assert_cs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_cs_n && !flash_cs_n));
  assert_oe_bus_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  assert_oe_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> ((&ram_we_n) && (&flash_we_n) && (ram_cs_n != flash_cs_n)));
  assert_ram_we_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ram_we_n) |-> (!ram_cs_n && (&flash_we_n) && mem_dq_oe));
  assert_flash_we_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&flash_we_n) |-> (!flash_cs_n && (&ram_we_n) && mem_dq_oe));
  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_we_low |=> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_dual_bank_mem_ctrl.sv
module test_dual_bank_mem_ctrl;

  localparam int PER = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_flash = 1'b0;
  logic        req_ready, done, mem_dq_oe, ram_cs_n, flash_cs_n, oe_n;
  logic [3:0]  req_mask = '0, ram_we_n, flash_we_n;
  logic [16:0] req_addr = '0, mem_addr;
  logic [31:0] req_wdata = '0, rdata, mem_dq_out;
  logic [31:0] mem_dq_in = 32'hDEAD_BEEF;

  always #(PER/2) clk = ~clk;

  dual_bank_mem_ctrl i_dual_bank_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_flash(req_flash), .req_mask(req_mask),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .ram_cs_n(ram_cs_n), .flash_cs_n(flash_cs_n),
    .oe_n(oe_n), .ram_we_n(ram_we_n), .flash_we_n(flash_we_n)
  );

  int total = 0, bad = 0, ticks = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<150000", ticks);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // independent timing arithmetic: smallest k with k*PER >= ns
  function automatic int cyc(input int ns);
    int k = 1;
    while (k * PER < ns) k++;
    return k;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int exp_strobe(input logic fl, input logic wr);
    if (wr) return fl ? cyc(45) : cyc(20);
    return fl ? cyc(70) : cyc(25);
  endfunction
  function automatic int exp_recov(input logic fl, input logic wr);
    if (wr) return fl ? mx(cyc(20), cyc(70) - 1 - cyc(45)) : mx(1, cyc(25) - 1 - cyc(20));
    return fl ? cyc(20) : cyc(12);
  endfunction
  function automatic logic [31:0] blank(input logic [16:0] a);
    return {15'd0, a};
  endfunction

  // pin-level memory model
  logic [31:0] ram_mem [int];
  logic [31:0] fl_mem [int];
  logic [31:0] ram_sh [int];
  logic [31:0] fl_sh [int];
  logic [3:0]  prev_rwe = 4'hF, prev_fwe = 4'hF;
  logic        prev_oe_n = 1'b1, prev_dq_oe = 1'b0, fl_seen_rise = 1'b0;
  int          cs_r = 0, cs_f = 0, oe_cnt = 0, fgap = 0, done_cnt = 0;
  int          rwe [4];
  int          fwe [4];
  logic        bad_r2 = 0, bad_r3 = 0, bad_r7 = 0, bad_r8 = 0;
  logic [16:0] cur_addr = '0;
  logic [31:0] cur_data = '0;

  always @(negedge clk) begin
    logic [31:0] t;
    if (rst_n) begin
      if (!ram_cs_n) cs_r++;
      if (!flash_cs_n) cs_f++;
      if (!oe_n) oe_cnt++;
      if (done) done_cnt++;
      for (int i = 0; i < 4; i++) begin
        if (!ram_we_n[i]) rwe[i]++;
        if (!flash_we_n[i]) fwe[i]++;
      end
      if (!ram_cs_n && !flash_cs_n) bad_r2 = 1;
      if (!oe_n && (mem_dq_oe || !(&ram_we_n) || !(&flash_we_n))) bad_r3 = 1;
      if (!oe_n && prev_oe_n && prev_dq_oe) bad_r3 = 1;
      if ((!(&ram_we_n) || !(&flash_we_n)) &&
          (mem_addr != cur_addr || mem_dq_out != cur_data || !mem_dq_oe)) bad_r8 = 1;
      if (&flash_we_n) fgap++;
      else if (&prev_fwe) begin
        if (fl_seen_rise && fgap < cyc(20)) bad_r7 = 1;
        fgap = 0;
      end
      for (int i = 0; i < 4; i++) begin
        if (!prev_rwe[i] && ram_we_n[i]) begin
          t = ram_mem.exists(int'(mem_addr)) ? ram_mem[int'(mem_addr)] : blank(mem_addr);
          t[8*i +: 8] = mem_dq_out[8*i +: 8];
          ram_mem[int'(mem_addr)] = t;
        end
        if (!prev_fwe[i] && flash_we_n[i]) begin
          t = fl_mem.exists(int'(mem_addr)) ? fl_mem[int'(mem_addr)] : blank(mem_addr);
          t[8*i +: 8] = mem_dq_out[8*i +: 8];
          fl_mem[int'(mem_addr)] = t;
          fl_seen_rise = 1;
        end
      end
    end
    prev_rwe = ram_we_n; prev_fwe = flash_we_n;
    prev_oe_n = oe_n; prev_dq_oe = mem_dq_oe;
    if (!oe_n && !ram_cs_n)
      mem_dq_in <= ram_mem.exists(int'(mem_addr)) ? ram_mem[int'(mem_addr)] : blank(mem_addr);
    else if (!oe_n && !flash_cs_n)
      mem_dq_in <= fl_mem.exists(int'(mem_addr)) ? fl_mem[int'(mem_addr)] : blank(mem_addr);
    else
      mem_dq_in <= 32'hDEAD_BEEF;
  end

  // {write, flash, mask[3:0], addr[16:0], data[31:0]}
  localparam logic [54:0] VEC [12] = '{
    {1'b1, 1'b0, 4'hF, 17'h00010, 32'h1122_3344},
    {1'b0, 1'b0, 4'h0, 17'h00010, 32'h0},
    {1'b1, 1'b0, 4'h5, 17'h00010, 32'hAABB_CCDD},
    {1'b0, 1'b0, 4'h0, 17'h00010, 32'h0},
    {1'b1, 1'b1, 4'hF, 17'h1FFFF, 32'h5566_7788},
    {1'b0, 1'b1, 4'h0, 17'h1FFFF, 32'h0},
    {1'b1, 1'b1, 4'h8, 17'h1FFFF, 32'h9900_0000},
    {1'b0, 1'b1, 4'h0, 17'h1FFFF, 32'h0},
    {1'b0, 1'b1, 4'h0, 17'h00010, 32'h0},
    {1'b1, 1'b0, 4'h0, 17'h00020, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 4'h0, 17'h00020, 32'h0},
    {1'b0, 1'b0, 4'h0, 17'h1FFFF, 32'h0}
  };

  logic [31:0] last_rd = '0;

  task automatic clear_counts();
    cs_r = 0; cs_f = 0; oe_cnt = 0;
    for (int i = 0; i < 4; i++) begin rwe[i] = 0; fwe[i] = 0; end
  endtask

  task automatic shadow_write(input logic fl, input logic [3:0] m,
                              input logic [16:0] a, input logic [31:0] d);
    logic [31:0] t;
    if (fl) t = fl_sh.exists(int'(a)) ? fl_sh[int'(a)] : blank(a);
    else    t = ram_sh.exists(int'(a)) ? ram_sh[int'(a)] : blank(a);
    for (int i = 0; i < 4; i++) if (m[i]) t[8*i +: 8] = d[8*i +: 8];
    if (fl) fl_sh[int'(a)] = t; else ram_sh[int'(a)] = t;
  endtask

  task automatic run(input logic [54:0] v);
    logic wr, fl; logic [3:0] m; logic [16:0] a; logic [31:0] d, expv;
    int lat, n, r;
    string tag;
    logic [63:0] lanes_act, lanes_exp;
    {wr, fl, m, a, d} = v;
    tag = wr ? (m == 0 ? "R11" : (fl ? "R7" : "R6")) : (fl ? "R5" : "R4");
    @(negedge clk); #1;
    clear_counts();
    cur_addr = a; cur_data = d;
    req_valid = 1; req_write = wr; req_flash = fl; req_mask = m;
    req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 300);
    #1;
    n = exp_strobe(fl, wr); r = exp_recov(fl, wr);
    chk({tag, " R10 latency"}, 64'(lat), 64'(n + r + 2));
    chk({tag, " chip select cycles"}, {32'(cs_r), 32'(cs_f)},
        fl ? {32'd0, 32'(n + 1)} : {32'(n + 1), 32'd0});
    chk({tag, " output enable cycles"}, 64'(oe_cnt), wr ? 64'd0 : 64'(n));
    for (int i = 0; i < 4; i++) begin
      lanes_act[8*i +: 8]      = 8'(rwe[i]);
      lanes_act[32 + 8*i +: 8] = 8'(fwe[i]);
      lanes_exp[8*i +: 8]      = (wr && !fl && m[i]) ? 8'(n) : 8'd0;
      lanes_exp[32 + 8*i +: 8] = (wr &&  fl && m[i]) ? 8'(n) : 8'd0;
    end
    chk({tag, " lane strobe cycles"}, lanes_act, lanes_exp);
    if (wr) begin
      shadow_write(fl, m, a, d);
      chk("R9 rdata held over write", 64'(rdata), 64'(last_rd));
    end else begin
      if (fl) expv = fl_sh.exists(int'(a)) ? fl_sh[int'(a)] : blank(a);
      else    expv = ram_sh.exists(int'(a)) ? ram_sh[int'(a)] : blank(a);
      chk({tag, " R9 read data"}, 64'(rdata), 64'(expv));
      last_rd = rdata;
    end
  endtask

  initial begin
    int dc0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {58'd0, ram_cs_n, flash_cs_n, oe_n, mem_dq_oe, req_ready, done},
        {58'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
    chk("R1 reset strobes", {56'd0, ram_we_n, flash_we_n}, {56'd0, 8'hFF});
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 12; k++) run(VEC[k]);
    // back-to-back flash writes exercise the R7 gap rule
    run({1'b1, 1'b1, 4'h1, 17'h00100, 32'h0000_00A5});
    run({1'b1, 1'b1, 4'h2, 17'h00100, 32'h0000_5A00});
    run({1'b0, 1'b1, 4'h0, 17'h00100, 32'h0});

    // R10: request held during a busy access is ignored
    dc0 = done_cnt;
    @(negedge clk); #1;
    cur_addr = 17'h00030; cur_data = 32'h1234_5678;
    req_valid = 1; req_write = 1; req_flash = 0; req_mask = 4'hF;
    req_addr = 17'h00030; req_wdata = 32'h1234_5678;
    @(posedge clk); #1;
    chk("R10 ready low when busy", 64'(req_ready), 64'd0);
    req_addr = 17'h00040; req_wdata = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    #1 req_valid = 0;
    repeat (20) @(negedge clk);
    chk("R10 one done per accepted request", 64'(done_cnt - dc0), 64'd1);
    shadow_write(1'b0, 4'hF, 17'h00030, 32'h1234_5678);
    run({1'b0, 1'b0, 4'h0, 17'h00040, 32'h0});
    run({1'b0, 1'b0, 4'h0, 17'h00030, 32'h0});

    chk("R2 chip selects exclusive", 64'(bad_r2), 64'd0);
    chk("R3 output enable rules", 64'(bad_r3), 64'd0);
    chk("R7 flash strobe high gap", 64'(bad_r7), 64'd0);
    chk("R8 address and data hold", 64'(bad_r8), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule